// File: doc/BRIEF.md
# Incremental Encoder Position and Revolution Counter

This block turns the A, B and index signals of an incremental shaft encoder into a position count and a revolution count. Each position unit is one counted edge. When the position runs past a programmable upper limit, it restarts at zero and the revolution count steps once. When it runs below zero, it reloads the limit and the revolution count steps back. A selected edge on the index input also returns the position to zero and steps the revolution count in the direction of the most recent count.

Three input modes read the A and B signals:
- two-times quadrature, which counts only the edges of A;
- four-times quadrature, which counts every edge of A and of B;
- plain up/down counting, where a chosen edge on A adds one and a chosen edge on B subtracts one.

A fourth mode code freezes the counter. Each input passes through a two-flop synchronizer before its edges are found. A set of compare values watches the position. Each compare value has a sticky match flag that software clears. A shared interrupt line stays high while any flag is set.

Top module: `enc_pos_rev_counter`

## Requirements
- R1: After synchronous reset, `pos_count`, `rev_count`, `match_flag` and `match_irq` are all zero, and the remembered direction is up.
- R2: An A or B level change driven between clock edges is counted on the third rising clock edge after the change. It is not visible on `pos_count` after only two rising edges.
- R3: In four-times quadrature mode (`count_mode` = 1), every edge of A or of B changes `pos_count` by one. The sequence in which A leads B (AB = 00, 10, 11, 01, 00) counts up. The sequence in which B leads A counts down.
- R4: In two-times quadrature mode (`count_mode` = 0), only edges of A are counted. Edges of B alone leave `pos_count` unchanged, so a full A-leads-B cycle adds two.
- R5: In either quadrature mode, an A edge and a B edge found in the same clock cycle produce no count.
- R6: In up/down mode (`count_mode` = 2), an edge of A chosen by `a_edge_sel` adds one and an edge of B chosen by `b_edge_sel` subtracts one. Edge-select codes are 0 none, 1 rising, 2 falling and 3 both. A chosen A edge and a chosen B edge in the same cycle cancel.
- R7: An up count while `pos_count` is at or above `pos_limit` sets `pos_count` to 0 and adds one to `rev_count`.
- R8: A down count while `pos_count` is 0 loads `pos_limit` into `pos_count` and subtracts one from `rev_count` (modulo 2^16).
- R9: An index edge chosen by `idx_edge_sel` (same codes as R6) clears `pos_count` and steps `rev_count` by one in the last counted direction. An A/B count in the same cycle is dropped, and index edges that are not chosen have no effect.
- R10: When `pos_count` takes a new value equal to compare slice k of `cmp_val` (bits 16k+15 down to 16k), `match_flag[k]` becomes 1 in the same cycle. It stays 1 until a one-cycle pulse on `match_clr[k]`.
- R11: `match_irq` is 1 exactly when at least one `match_flag` bit is 1, updating on the same edge.
- R12: With `count_mode` = 3, edges on A and B leave `pos_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index pulse (asynchronous) |
| count_mode | input | 2 | 0 quad x2, 1 quad x4, 2 up/down, 3 hold |
| a_edge_sel | input | 2 | Counted A edge in up/down mode |
| b_edge_sel | input | 2 | Counted B edge in up/down mode |
| idx_edge_sel | input | 2 | Index edge that triggers zeroing |
| pos_limit | input | 16 | Highest position value before wrap |
| cmp_val | input | 32 | Compare values, 16 bits per slot |
| match_clr | input | 2 | One-cycle clear pulse per match flag |
| pos_count | output | 16 | Position count |
| rev_count | output | 16 | Revolution count |
| match_flag | output | 2 | Sticky compare match flags |
| match_irq | output | 1 | OR of all match flags |

## Verification
The bench drives A and B in both phase orders in four-times mode, which tells up counting from down counting. It repeats the same forward cycle in two-times mode, where B-only edges must be ignored, so this separates the two resolutions. Edges on A and B arriving together are driven as well, and in up/down mode A and B are pulsed with different edge selections, so a wrong edge decode shows up as a different total. Wrap-up, wrap-down, index zeroing in both directions, the case where index and count arrive in the same cycle, compare set and clear, and hold mode each have their own scenario, started from reset so that their expected counts are exact.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD_X2 = 2'd0,
    MODE_QUAD_X4 = 2'd1,
    MODE_UPDOWN  = 2'd2,
    MODE_HOLD    = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic level;
  } edge_evt_t;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    logic hit;
    case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/qpr_sync_edge.sv
module qpr_sync_edge
  import qpr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  output edge_evt_t evt
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  always_comb begin
    evt.level = chain_q[STAGES-1];
    evt.rise  = chain_q[STAGES-1] & ~prev_q;
    evt.fall  = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/qpr_decode.sv
module qpr_decode
  import qpr_pkg::*;
(
  input  edge_evt_t a_evt,
  input  edge_evt_t b_evt,
  input  cnt_mode_e mode,
  input  edge_sel_e a_sel,
  input  edge_sel_e b_sel,
  output logic      inc,
  output logic      dec
);

  logic a_any, b_any;
  logic a_up, b_up;
  logic a_hit, b_hit;

  assign a_any = a_evt.rise | a_evt.fall;
  assign b_any = b_evt.rise | b_evt.fall;
  // after an A edge: levels differ means A moved first (forward)
  assign a_up  = a_evt.level ^ b_evt.level;
  // after a B edge: levels equal means B followed A (forward)
  assign b_up  = ~(a_evt.level ^ b_evt.level);
  assign a_hit = edge_hit(a_sel, a_evt.rise, a_evt.fall);
  assign b_hit = edge_hit(b_sel, b_evt.rise, b_evt.fall);

  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    case (mode)
      MODE_QUAD_X2: begin
        if (a_any && !b_any) begin
          inc = a_up;
          dec = ~a_up;
        end
      end
      MODE_QUAD_X4: begin
        if (a_any && !b_any) begin
          inc = a_up;
          dec = ~a_up;
        end else if (b_any && !a_any) begin
          inc = b_up;
          dec = ~b_up;
        end
      end
      MODE_UPDOWN: begin
        inc = a_hit & ~b_hit;
        dec = b_hit & ~a_hit;
      end
      default: begin
        inc = 1'b0;
        dec = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/qpr_pos_rev.sv
module qpr_pos_rev #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic         zero_hit,
  input  logic [W-1:0] pos_max,
  output logic [W-1:0] pos_q,
  output logic [W-1:0] rev_q,
  output logic [W-1:0] pos_nxt,
  output logic         pos_load
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] rev_nxt;
  logic         dir_q, dir_nxt;

  assign pos_load = zero_hit | inc | dec;

  always_comb begin
    pos_nxt = pos_q;
    rev_nxt = rev_q;
    dir_nxt = dir_q;
    if (zero_hit) begin
      pos_nxt = '0;
      rev_nxt = dir_q ? rev_q + ONE : rev_q - ONE;
    end else if (inc) begin
      dir_nxt = 1'b1;
      if (pos_q >= pos_max) begin
        pos_nxt = '0;
        rev_nxt = rev_q + ONE;
      end else begin
        pos_nxt = pos_q + ONE;
      end
    end else if (dec) begin
      dir_nxt = 1'b0;
      if (pos_q == '0) begin
        pos_nxt = pos_max;
        rev_nxt = rev_q - ONE;
      end else begin
        pos_nxt = pos_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      rev_q <= '0;
      dir_q <= 1'b1;
    end else begin
      pos_q <= pos_nxt;
      rev_q <= rev_nxt;
      dir_q <= dir_nxt;
    end
  end

endmodule

// File: rtl/qpr_compare.sv
module qpr_compare #(
  parameter int W    = 16,
  parameter int NCMP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pos_load,
  input  logic [W-1:0]      pos_nxt,
  input  logic [NCMP*W-1:0] cmp_vals,
  input  logic [NCMP-1:0]   clr,
  output logic [NCMP-1:0]   flags_q,
  output logic              irq_q
);

  logic [NCMP-1:0] flags_d;

  for (genvar k = 0; k < NCMP; k++) begin : g_slot
    logic set_k;
    assign set_k      = pos_load && (pos_nxt == cmp_vals[k*W +: W]);
    assign flags_d[k] = set_k | (flags_q[k] & ~clr[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |flags_d;
    end
  end

endmodule

// File: rtl/enc_pos_rev_counter.sv
module enc_pos_rev_counter
  import qpr_pkg::*;
#(
  parameter int W           = 16,
  parameter int NCMP        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic [1:0]        count_mode,
  input  logic [1:0]        a_edge_sel,
  input  logic [1:0]        b_edge_sel,
  input  logic [1:0]        idx_edge_sel,
  input  logic [W-1:0]      pos_limit,
  input  logic [NCMP*W-1:0] cmp_val,
  input  logic [NCMP-1:0]   match_clr,
  output logic [W-1:0]      pos_count,
  output logic [W-1:0]      rev_count,
  output logic [NCMP-1:0]   match_flag,
  output logic              match_irq
);

  localparam int NIN = 3;

  logic [NIN-1:0] raw_in;
  edge_evt_t      evt [NIN];
  logic           cnt_inc, cnt_dec, idx_hit;
  logic [W-1:0]   pos_nxt;
  logic           pos_load;
  logic           unused_idx_level;

  assign raw_in = {enc_idx, enc_b, enc_a};

  for (genvar g = 0; g < NIN; g++) begin : g_in
    qpr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_in[g]),
      .evt (evt[g])
    );
  end

  assign idx_hit          = edge_hit(edge_sel_e'(idx_edge_sel), evt[2].rise, evt[2].fall);
  assign unused_idx_level = evt[2].level;

  qpr_decode u_decode (
    .a_evt (evt[0]),
    .b_evt (evt[1]),
    .mode  (cnt_mode_e'(count_mode)),
    .a_sel (edge_sel_e'(a_edge_sel)),
    .b_sel (edge_sel_e'(b_edge_sel)),
    .inc   (cnt_inc),
    .dec   (cnt_dec)
  );

  qpr_pos_rev #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc      (cnt_inc),
    .dec      (cnt_dec),
    .zero_hit (idx_hit),
    .pos_max  (pos_limit),
    .pos_q    (pos_count),
    .rev_q    (rev_count),
    .pos_nxt  (pos_nxt),
    .pos_load (pos_load)
  );

  qpr_compare #(.W(W), .NCMP(NCMP)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .pos_load (pos_load),
    .pos_nxt  (pos_nxt),
    .cmp_vals (cmp_val),
    .clr      (match_clr),
    .flags_q  (match_flag),
    .irq_q    (match_irq)
  );

endmodule

// File: rtl/qpr_checker.sv
module qpr_checker #(
  parameter int W    = 16,
  parameter int NCMP = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            inc,
  input logic            dec,
  input logic            z_hit,
  input logic [W-1:0]    pos_count,
  input logic [W-1:0]    rev_count,
  input logic [W-1:0]    pos_limit,
  input logic [NCMP-1:0] match_flag,
  input logic [NCMP-1:0] match_clr,
  input logic            match_irq
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r5_single_dir: assert property (@(posedge clk) disable iff (rst)
    !(inc && dec));

  a_r7_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (inc && !z_hit && pos_count >= pos_limit) |=>
      (pos_count == '0) && (rev_count == $past(rev_count) + ONE));

  a_r8_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (dec && !z_hit && pos_count == '0) |=>
      (pos_count == $past(pos_limit)) && (rev_count == $past(rev_count) - ONE));

  a_r9_index_zero: assert property (@(posedge clk) disable iff (rst)
    z_hit |=> (pos_count == '0) && (rev_count != $past(rev_count)));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec && !z_hit) |=>
      (pos_count == $past(pos_count)) && (rev_count == $past(rev_count)));

  a_r11_irq_or: assert property (@(posedge clk) disable iff (rst)
    match_irq == (|match_flag));

  for (genvar k = 0; k < NCMP; k++) begin : g_flag
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      (match_flag[k] && !match_clr[k]) |=> match_flag[k]);
  end

endmodule

bind enc_pos_rev_counter qpr_checker #(.W(W), .NCMP(NCMP)) u_qpr_chk (
  .clk        (clk),
  .rst        (rst),
  .inc        (cnt_inc),
  .dec        (cnt_dec),
  .z_hit      (idx_hit),
  .pos_count  (pos_count),
  .rev_count  (rev_count),
  .pos_limit  (pos_limit),
  .match_flag (match_flag),
  .match_clr  (match_clr),
  .match_irq  (match_irq)
);

// File: tb/enc_pos_rev_counter_bench.sv
module enc_pos_rev_counter_bench;

  localparam int W    = 16;
  localparam int NCMP = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic [1:0]        count_mode = 2'd1;
  logic [1:0]        a_edge_sel = 2'd1, b_edge_sel = 2'd1, idx_edge_sel = 2'd1;
  logic [W-1:0]      pos_limit = 16'd100;
  logic [NCMP*W-1:0] cmp_val = '1;
  logic [NCMP-1:0]   match_clr = '0;
  logic [W-1:0]      pos_count, rev_count;
  logic [NCMP-1:0]   match_flag;
  logic              match_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  enc_pos_rev_counter #(.W(W), .NCMP(NCMP), .SYNC_STAGES(2)) u_enc_pos_rev_counter (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .count_mode(count_mode), .a_edge_sel(a_edge_sel), .b_edge_sel(b_edge_sel),
    .idx_edge_sel(idx_edge_sel), .pos_limit(pos_limit), .cmp_val(cmp_val),
    .match_clr(match_clr), .pos_count(pos_count), .rev_count(rev_count),
    .match_flag(match_flag), .match_irq(match_irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic [W-1:0] lim);
    @(negedge clk);
    rst = 1'b1; enc_a = 0; enc_b = 0; enc_idx = 0; match_clr = '0;
    count_mode = mode; pos_limit = lim;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic b, input logic z);
    @(negedge clk);
    enc_a = a; enc_b = b; enc_idx = z;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a(); drive(1, enc_b, enc_idx); drive(0, enc_b, enc_idx); endtask
  task automatic pulse_b(); drive(enc_a, 1, enc_idx); drive(enc_a, 0, enc_idx); endtask
  task automatic pulse_z(); drive(enc_a, enc_b, 1); drive(enc_a, enc_b, 0); endtask

  task automatic t_reset();
    do_reset(2'd1, 16'd100);
    check("R1", "pos after reset", pos_count, 0);
    check("R1", "rev after reset", rev_count, 0);
    check("R1", "flags after reset", match_flag, 0);
    check("R1", "irq after reset", match_irq, 0);
  endtask

  task automatic t_x4();
    do_reset(2'd1, 16'd100);
    @(negedge clk);
    enc_a = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", "pos two edges after change", pos_count, 0);
    @(negedge clk);
    check("R2", "pos three edges after change", pos_count, 1);
    drive(1, 1, 0); drive(0, 1, 0); drive(0, 0, 0);
    check("R3", "A leads B x4", pos_count, 4);
    drive(0, 1, 0); drive(1, 1, 0); drive(1, 0, 0);
    check("R3", "B leads A partial", pos_count, 1);
    drive(0, 0, 0);
    check("R3", "B leads A full", pos_count, 0);
  endtask

  task automatic t_x2();
    do_reset(2'd0, 16'd100);
    drive(1, 0, 0);
    drive(1, 1, 0);
    check("R4", "B edge ignored x2", pos_count, 1);
    drive(0, 1, 0); drive(0, 0, 0);
    check("R4", "forward cycle x2", pos_count, 2);
    drive(0, 1, 0); drive(1, 1, 0);
    check("R4", "reverse A edge x2", pos_count, 1);
  endtask

  task automatic t_simul();
    do_reset(2'd1, 16'd100);
    drive(1, 1, 0);
    check("R5", "A and B together up", pos_count, 0);
    drive(0, 0, 0);
    check("R5", "A and B together down", rev_count, 0);
    check("R5", "A and B together down pos", pos_count, 0);
  endtask

  task automatic t_updown();
    a_edge_sel = 2'd1; b_edge_sel = 2'd3;
    do_reset(2'd2, 16'd100);
    pulse_a(); pulse_a(); pulse_a();
    check("R6", "A rising counted once per pulse", pos_count, 3);
    pulse_b();
    check("R6", "B both edges down", pos_count, 1);
    drive(1, 1, 0);
    check("R6", "A and B rise cancel", pos_count, 1);
    drive(0, 0, 0);
    check("R6", "only B fall counts", pos_count, 0);
    b_edge_sel = 2'd1;
  endtask

  task automatic t_wrap();
    a_edge_sel = 2'd1; b_edge_sel = 2'd1;
    do_reset(2'd2, 16'd3);
    pulse_a(); pulse_a(); pulse_a();
    check("R7", "at limit", pos_count, 3);
    pulse_a();
    check("R7", "wrap up pos", pos_count, 0);
    check("R7", "wrap up rev", rev_count, 1);
    do_reset(2'd2, 16'd3);
    pulse_b();
    check("R8", "wrap down pos", pos_count, 3);
    check("R8", "wrap down rev", rev_count, 16'hFFFF);
  endtask

  task automatic t_index();
    a_edge_sel = 2'd1; b_edge_sel = 2'd1; idx_edge_sel = 2'd1;
    do_reset(2'd2, 16'd100);
    pulse_a(); pulse_a(); pulse_a();
    drive(0, 0, 1);
    check("R9", "index clears pos", pos_count, 0);
    check("R9", "index steps rev up", rev_count, 1);
    drive(0, 0, 0);
    check("R9", "unselected index fall", rev_count, 1);
    pulse_b(); pulse_b();
    check("R9", "pos after down counts", pos_count, 99);
    pulse_z();
    check("R9", "index down pos", pos_count, 0);
    check("R9", "index steps rev down", rev_count, 16'hFFFF);
    drive(1, 0, 1);
    check("R9", "index beats count pos", pos_count, 0);
    check("R9", "index beats count rev", rev_count, 16'hFFFE);
    drive(0, 0, 0);
    pulse_a();
    check("R9", "count after index", pos_count, 1);
  endtask

  task automatic t_compare();
    a_edge_sel = 2'd1;
    cmp_val = {16'd5, 16'd2};
    do_reset(2'd2, 16'd100);
    pulse_a();
    check("R10", "no match at 1", match_flag, 2'b00);
    pulse_a();
    check("R10", "match slot0", match_flag, 2'b01);
    check("R11", "irq with flag", match_irq, 1);
    pulse_a();
    check("R10", "flag sticky", match_flag, 2'b01);
    @(negedge clk); match_clr = 2'b01;
    @(negedge clk); match_clr = 2'b00;
    @(negedge clk);
    check("R10", "flag cleared", match_flag, 2'b00);
    check("R11", "irq low after clear", match_irq, 0);
    pulse_a(); pulse_a();
    check("R10", "match slot1", match_flag, 2'b10);
    check("R11", "irq from slot1", match_irq, 1);
  endtask

  task automatic t_hold();
    a_edge_sel = 2'd3; b_edge_sel = 2'd3;
    do_reset(2'd3, 16'd100);
    drive(1, 0, 0); drive(1, 1, 0); drive(0, 1, 0); drive(0, 0, 0);
    pulse_a(); pulse_b();
    check("R12", "hold mode pos", pos_count, 0);
    check("R12", "hold mode rev", rev_count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_x4();
    t_x2();
    t_simul();
    t_updown();
    t_wrap();
    t_index();
    t_compare();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule